// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses the control-memory address of the next microinstruction in a microprogrammed control unit. It keeps a control address register (the current microinstruction address) and, on every rising clock edge, reloads it from one of four sources. The four sources are the current address plus one, the branch-target field of the current microinstruction, an address formed from the machine-instruction opcode, and a single saved return address.

The control word supplies three fields: a condition selector, a two-bit branch kind and a branch target. A condition selector picks one status flag (zero, carry, overflow, negative), or a constant true for an unconditional transfer, or a constant false. Jumps and calls are taken only when the selected condition holds. A taken call also records the address after the call, so that a later return resumes there. The map kind sends control to a fixed four-slot routine per opcode in the lower half of control memory. The upper half is left free for longer routines.

Top module: `nas_sequencer`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high at a rising edge, `car` becomes 0 and `ret_addr` becomes 0.
- R2: With `br_kind` = 00 (jump) and the selected condition true, `car` takes `br_target` at the next edge.
- R3: With `br_kind` = 00 (jump) or 01 (call) and the selected condition false, `car` takes its old value plus one.
- R4: `cond_sel` = 0 is a condition that is always true, whatever `flags` holds.
- R5: `cond_sel` values 1, 2, 3 and 4 select `flags` bit 0 (zero), bit 1 (carry), bit 2 (overflow) and bit 3 (negative) respectively.
- R6: `cond_sel` values 5, 6 and 7 are never true, so a jump or call with these values only increments `car`.
- R7: With `br_kind` = 01 (call) and the condition true, `car` takes `br_target` and `ret_addr` takes the old `car` plus one.
- R8: A call whose condition is false leaves `ret_addr` unchanged.
- R9: With `br_kind` = 10 (return), `car` takes the value of `ret_addr`, whatever the condition or `br_target`.
- R10: With `br_kind` = 11 (map), `car` takes bit 6 = 0, bits 5..2 = `opcode` and bits 1..0 = 0, whatever the condition, flags or target.
- R11: Jump, return and map leave `ret_addr` unchanged.
- R12: Incrementing `car` from 127 wraps it to 0, and a call made at 127 saves 0 as the return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 3 | Condition selector from the microinstruction |
| br_kind | input | 2 | Branch kind: 00 jump, 01 call, 10 return, 11 map |
| br_target | input | 7 | Branch target field of the microinstruction |
| opcode | input | 4 | Opcode of the machine instruction being decoded |
| flags | input | 4 | Status flags: bit 0 zero, 1 carry, 2 overflow, 3 negative |
| car | output | 7 | Control address register (next microinstruction address) |
| ret_addr | output | 7 | Saved subroutine return address |

## Verification
The bench walks each flag through its selector with the flag alone set and then with every other flag set. A mux that is wired one position off, or that ignores a flag, then jumps where it should step, or steps where it should jump. Reserved selectors are driven with all flags high, which exposes a design that folds them onto a real flag. A call made at address 127 and a plain increment at 127 check the wrap, which a sequencer with a carry into a wider register would get wrong. The return register is read back after untaken calls, jumps and maps: a design that saves on every call, or that saves on a map, resumes at the wrong place after the next return. Map addresses are checked for opcodes 0, 5, 10 and 15 with other fields set to confusing values, which catches a shifted or reversed opcode field.

// File: rtl/nas_pkg.sv
package nas_pkg;

   // Branch kind carried in the microinstruction
   typedef enum logic [1:0] {
      BK_JUMP = 2'b00,
      BK_CALL = 2'b01,
      BK_RET  = 2'b10,
      BK_MAP  = 2'b11
   } br_kind_e;

   // Source feeding the control address register
   typedef enum logic [1:0] {
      SRC_INC    = 2'd0,
      SRC_TARGET = 2'd1,
      SRC_MAP    = 2'd2,
      SRC_RETURN = 2'd3
   } car_src_e;

   // Selector code reserved for the constant-true condition
   localparam int unsigned COND_ALWAYS_CODE = 0;

endpackage

// File: rtl/nas_cond_mux.sv
module nas_cond_mux #(
   parameter int unsigned SEL_W     = 3,
   parameter int unsigned NUM_FLAGS = 4
) (
   input  logic [SEL_W-1:0]     sel,
   input  logic [NUM_FLAGS-1:0] flags,
   output logic                 hit
);
   import nas_pkg::*;

   localparam int unsigned NUM_CODES = 1 << SEL_W;

   // Elaboration-time parameter checks
   if (NUM_FLAGS + 1 > NUM_CODES) begin : g_chk_sel
      $error("nas_cond_mux: SEL_W too narrow for NUM_FLAGS plus the always code");
   end
   if (NUM_FLAGS < 1) begin : g_chk_flags
      $error("nas_cond_mux: at least one status flag is required");
   end

   logic [NUM_CODES-1:0] candidate;

   // Code 0 is constant true, codes 1..NUM_FLAGS pick a flag, the rest are false
   for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
      if (g == COND_ALWAYS_CODE) begin : g_always
         assign candidate[g] = 1'b1;
      end else if (g <= NUM_FLAGS) begin : g_flag
         assign candidate[g] = flags[g-1];
      end else begin : g_reserved
         assign candidate[g] = 1'b0;
      end
   end

   assign hit = candidate[sel];

endmodule

// File: rtl/nas_opcode_map.sv
module nas_opcode_map #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned OPC_W  = 4,
   parameter int unsigned SLOT_W = 2
) (
   input  logic [OPC_W-1:0]  opcode,
   output logic [ADDR_W-1:0] map_addr
);
   localparam int unsigned PAD_W = ADDR_W - OPC_W - SLOT_W;

   // Top bit must stay zero so the upper half remains free
   if (ADDR_W < OPC_W + SLOT_W + 1) begin : g_chk_width
      $error("nas_opcode_map: ADDR_W must exceed OPC_W + SLOT_W");
   end

   // Routine slots sit at the low end of each opcode's block
   if (SLOT_W == 0) begin : g_no_slots
      assign map_addr = {{PAD_W{1'b0}}, opcode};
   end else begin : g_slots
      assign map_addr = {{PAD_W{1'b0}}, opcode, {SLOT_W{1'b0}}};
   end

endmodule

// File: rtl/nas_src_sel.sv
module nas_src_sel (
   input  logic [1:0]          kind,
   input  logic                hit,
   output nas_pkg::car_src_e   src,
   output logic                save_ret
);
   import nas_pkg::*;

   br_kind_e kind_e;
   assign kind_e = br_kind_e'(kind);

   // The condition gates only jump and call
   always_comb begin
      src      = SRC_INC;
      save_ret = 1'b0;
      unique case (kind_e)
         BK_JUMP: begin
            src = hit ? SRC_TARGET : SRC_INC;
         end
         BK_CALL: begin
            src      = hit ? SRC_TARGET : SRC_INC;
            save_ret = hit;
         end
         BK_RET: begin
            src = SRC_RETURN;
         end
         BK_MAP: begin
            src = SRC_MAP;
         end
         default: begin
            src = SRC_INC;
         end
      endcase
   end

endmodule

// File: rtl/nas_return_reg.sv
module nas_return_reg #(
   parameter int unsigned       ADDR_W     = 7,
   parameter logic [ADDR_W-1:0] RESET_VAL  = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              save,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= RESET_VAL;
      end else if (save) begin
         q <= d;
      end
   end

   // Only a taken call may disturb the saved address
   assert_ret_hold_R11: assert property (@(posedge clk) disable iff (rst)
      !save |=> $stable(q));

endmodule

// File: rtl/nas_sequencer.sv
module nas_sequencer #(
   parameter int unsigned ADDR_W     = 7,
   parameter int unsigned OPC_W      = 4,
   parameter int unsigned SLOT_W     = 2,
   parameter int unsigned NUM_FLAGS  = 4,
   parameter int unsigned SEL_W      = 3,
   parameter int unsigned RESET_ADDR = 0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [SEL_W-1:0]     cond_sel,
   input  logic [1:0]           br_kind,
   input  logic [ADDR_W-1:0]    br_target,
   input  logic [OPC_W-1:0]     opcode,
   input  logic [NUM_FLAGS-1:0] flags,
   output logic [ADDR_W-1:0]    car,
   output logic [ADDR_W-1:0]    ret_addr
);
   import nas_pkg::*;

   localparam logic [ADDR_W-1:0] RST_ADDR_V = ADDR_W'(RESET_ADDR);
   localparam logic [ADDR_W-1:0] ONE_V      = ADDR_W'(1);

   if (RESET_ADDR >= (1 << ADDR_W)) begin : g_chk_reset
      $error("nas_sequencer: RESET_ADDR does not fit in ADDR_W bits");
   end

   logic              cond_hit;
   logic [ADDR_W-1:0] car_inc;
   logic [ADDR_W-1:0] map_addr;
   logic [ADDR_W-1:0] car_next;
   logic              save_ret;
   car_src_e          src;

   nas_cond_mux #(
      .SEL_W     (SEL_W),
      .NUM_FLAGS (NUM_FLAGS)
   ) cond_i (
      .sel   (cond_sel),
      .flags (flags),
      .hit   (cond_hit)
   );

   nas_opcode_map #(
      .ADDR_W (ADDR_W),
      .OPC_W  (OPC_W),
      .SLOT_W (SLOT_W)
   ) map_i (
      .opcode   (opcode),
      .map_addr (map_addr)
   );

   nas_src_sel sel_i (
      .kind     (br_kind),
      .hit      (cond_hit),
      .src      (src),
      .save_ret (save_ret)
   );

   // Incrementer wraps at the top of control memory
   assign car_inc = car + ONE_V;

   nas_return_reg #(
      .ADDR_W    (ADDR_W),
      .RESET_VAL (RST_ADDR_V)
   ) ret_i (
      .clk  (clk),
      .rst  (rst),
      .save (save_ret),
      .d    (car_inc),
      .q    (ret_addr)
   );

   // Four-way source mux
   always_comb begin
      unique case (src)
         SRC_INC:    car_next = car_inc;
         SRC_TARGET: car_next = br_target;
         SRC_MAP:    car_next = map_addr;
         SRC_RETURN: car_next = ret_addr;
         default:    car_next = car_inc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         car <= RST_ADDR_V;
      end else begin
         car <= car_next;
      end
   end

   // Assertions beside the address register
   assert_reset_addr_R1: assert property (@(posedge clk)
      rst |=> (car == RST_ADDR_V && ret_addr == RST_ADDR_V));

   assert_step_untaken_R3: assert property (@(posedge clk) disable iff (rst)
      ((br_kind == BK_JUMP || br_kind == BK_CALL) && !cond_hit)
      |=> car == $past(car) + ONE_V);

   assert_reserved_false_R6: assert property (@(posedge clk) disable iff (rst)
      (cond_sel > SEL_W'(NUM_FLAGS)) |-> !cond_hit);

   assert_call_saves_R7: assert property (@(posedge clk) disable iff (rst)
      (br_kind == BK_CALL && cond_hit)
      |=> (car == $past(br_target) && ret_addr == $past(car) + ONE_V));

   assert_return_load_R9: assert property (@(posedge clk) disable iff (rst)
      (br_kind == BK_RET) |=> car == $past(ret_addr));

   assert_map_layout_R10: assert property (@(posedge clk) disable iff (rst)
      (br_kind == BK_MAP)
      |=> (car[ADDR_W-1] == 1'b0 && car[SLOT_W +: OPC_W] == $past(opcode)));

endmodule

// File: tb/nas_sequencer_tb.sv
module nas_sequencer_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] cond_sel = '0;
   logic [1:0] br_kind = '0;
   logic [6:0] br_target = '0;
   logic [3:0] opcode = '0;
   logic [3:0] flags = '0;
   logic [6:0] car;
   logic [6:0] ret_addr;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   localparam logic [1:0] K_JMP = 2'b00;
   localparam logic [1:0] K_CAL = 2'b01;
   localparam logic [1:0] K_RET = 2'b10;
   localparam logic [1:0] K_MAP = 2'b11;

   always #4 clk = ~clk;

   nas_sequencer dut_i (
      .clk       (clk),
      .rst       (rst),
      .cond_sel  (cond_sel),
      .br_kind   (br_kind),
      .br_target (br_target),
      .opcode    (opcode),
      .flags     (flags),
      .car       (car),
      .ret_addr  (ret_addr)
   );

   task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   // Drive one microinstruction at a falling edge, return after the next falling edge
   task automatic step(input logic [1:0] k, input logic [2:0] s, input logic [6:0] t,
                       input logic [3:0] op, input logic [3:0] f);
      br_kind = k; cond_sel = s; br_target = t; opcode = op; flags = f;
      @(negedge clk);
   endtask

   task automatic go_to(input logic [6:0] a);
      step(K_JMP, 3'd0, a, 4'h0, 4'h0);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      step(K_JMP, 3'd0, 7'h5A, 4'h3, 4'hF);
      chk("R1 car", car, 7'h00);
      chk("R1 ret", ret_addr, 7'h00);
      rst = 1'b0;
   endtask

   task automatic t_reset_mid;
      go_to(7'h33);
      step(K_CAL, 3'd0, 7'h44, 4'h0, 4'h0);
      rst = 1'b1;
      step(K_JMP, 3'd0, 7'h66, 4'h0, 4'h0);
      chk("R1 car after run", car, 7'h00);
      chk("R1 ret after run", ret_addr, 7'h00);
      rst = 1'b0;
   endtask

   task automatic t_jump_always;
      step(K_JMP, 3'd0, 7'h55, 4'h0, 4'h0);
      chk("R4 always with no flags", car, 7'h55);
      step(K_JMP, 3'd0, 7'h12, 4'h0, 4'hF);
      chk("R2 jump taken", car, 7'h12);
   endtask

   task automatic t_flag_select;
      for (int i = 0; i < 4; i++) begin
         go_to(7'h10);
         step(K_JMP, 3'(i + 1), 7'h60, 4'h0, 4'(1 << i));
         chk("R5 flag alone selects taken", car, 7'h60);
         go_to(7'h10);
         step(K_JMP, 3'(i + 1), 7'h60, 4'h0, ~4'(1 << i));
         chk("R3 flag clear steps", car, 7'h11);
      end
   endtask

   task automatic t_reserved;
      for (int s = 5; s < 8; s++) begin
         go_to(7'h20);
         step(K_JMP, 3'(s), 7'h70, 4'h0, 4'hF);
         chk("R6 reserved jump", car, 7'h21);
      end
      go_to(7'h24);
      step(K_CAL, 3'd7, 7'h70, 4'h0, 4'hF);
      chk("R6 reserved call", car, 7'h25);
   endtask

   task automatic t_wrap;
      go_to(7'h7F);
      step(K_JMP, 3'd5, 7'h30, 4'h0, 4'h0);
      chk("R12 wrap", car, 7'h00);
      go_to(7'h7F);
      step(K_CAL, 3'd0, 7'h30, 4'h0, 4'h0);
      chk("R12 call at top target", car, 7'h30);
      chk("R12 call at top ret", ret_addr, 7'h00);
   endtask

   task automatic t_call_return;
      go_to(7'h20);
      step(K_CAL, 3'd0, 7'h70, 4'h0, 4'h0);
      chk("R7 call target", car, 7'h70);
      chk("R7 call saves", ret_addr, 7'h21);
      step(K_JMP, 3'd0, 7'h40, 4'h0, 4'h0);
      chk("R11 jump keeps ret", ret_addr, 7'h21);
      step(K_MAP, 3'd0, 7'h40, 4'h9, 4'h0);
      chk("R11 map keeps ret", ret_addr, 7'h21);
      step(K_RET, 3'd6, 7'h0B, 4'h0, 4'h0);
      chk("R9 return", car, 7'h21);
      chk("R11 return keeps ret", ret_addr, 7'h21);
   endtask

   task automatic t_call_untaken;
      go_to(7'h08);
      step(K_CAL, 3'd0, 7'h50, 4'h0, 4'h0);
      chk("R7 second call saves", ret_addr, 7'h09);
      go_to(7'h30);
      step(K_CAL, 3'd1, 7'h50, 4'h0, 4'hE);
      chk("R3 call untaken steps", car, 7'h31);
      chk("R8 call untaken keeps ret", ret_addr, 7'h09);
   endtask

   task automatic t_map;
      logic [3:0] ops [4] = '{4'h0, 4'h5, 4'hA, 4'hF};
      for (int i = 0; i < 4; i++) begin
         go_to(7'h7E);
         step(K_MAP, 3'(i + 4), 7'h7F, ops[i], 4'(i * 5));
         chk("R10 map", car, {1'b0, ops[i], 2'b00});
      end
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_jump_always();
      t_flag_select();
      t_reserved();
      t_wrap();
      t_call_return();
      t_call_untaken();
      t_map();
      t_reset_mid();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule